// File: doc/BRIEF.md
# Extended Capability Chain Search Engine

This block searches the chained list of extended capabilities that lives in a 4 KB configuration space, hunting for one vendor-specific entry identified by a sub-identifier and a byte length. After a start pulse it issues single 32-bit word reads through a request/acknowledge read port. The list begins at byte offset 0x100. The block decodes each header and follows the next pointers, and it stops as soon as a pointer leaves the legal window.

Every header that carries the vendor-specific code costs a second read, of the word four bytes above it. That word is compared with the target sub-identifier and length. The search ends in one of two ways. Either the target is found, and the base offset of its header is reported. Or the chain runs out, and the result is "not found". Completion is marked by a single-cycle done pulse. The result then holds until the next start.

The configuration space itself sits outside the block and is reached only through the read port. The block never writes to that space.

Top module: `ecap_walker`

## Requirements
- R1: After reset the outputs are as follows: busy_o, done_o, found_o and rd_req_o are 0, and cap_ofs_o is 0.
- R2: A start pulse while idle raises busy_o on the next cycle. The first read is of byte offset 0x100. busy_o stays high until the cycle in which done_o pulses, where busy_o is 0.
- R3: Header word layout: identifier in bits [15:0], version in bits [19:16], next pointer in bits [31:20]. When the identifier is not 0x000B, only the header is read, and the next read is at the byte offset given by the next pointer.
- R4: When the identifier is 0x000B, the word at header offset + 4 is read next. That word holds the sub-identifier in bits [15:0], the revision in bits [19:16] and the length in bits [31:20]. A sub-identifier of 0x0008 together with a length of 0x020 is a match, and the version and revision bits play no part in it.
- R5: For a vendor-specific header whose second word does not match (wrong sub-identifier or wrong length), the walk continues at the next pointer of the header word.
- R6: A next pointer below 0x100, including 0, ends the walk as not found with no further read.
- R7: No read is ever issued to an offset above 4092. A next pointer above 4092 ends the walk as not found.
- R8: A match is reported as found only when its base offset lies between 0x100 and 4064 (0xFE0) inclusive. A match above 4064 ends the walk as not found.
- R9: A vendor-specific header at an offset above 4088, whose second word would lie outside the space, ends the walk as not found without reading that second word.
- R10: done_o is high for exactly one cycle per walk. found_o and cap_ofs_o (the base offset when found, 0 when not found) hold until the next start, and a start clears them.
- R11: rd_req_o stays high with a stable rd_addr_o until rd_ack_i is seen, and it drops after the acknowledge. Only one read is ever outstanding.
- R12: A start pulse while busy_o is high is ignored: the walk in progress, its reads and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a walk |
| found_o | output | 1 | The last walk found the target capability |
| cap_ofs_o | output | 12 | Base byte offset of the found capability, 0 otherwise |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | 12 | Byte offset of the requested word |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid with it |
| rd_data_i | input | 32 | Read data |

## Verification
The bench builds the block with its default parameters: a 4096-byte space, a list start of 0x100, vendor code 0x000B, sub-identifier 0x0008 and length 0x020. With these values the full 12-bit next-pointer range covers the whole space. That puts the edges of the window within reach of single pointers: 0xFE0 against 0xFE4 for the found window, 0xFFC for a second word that would fall outside the space, and 0xFFF and 0x0F0 for pointers out of range. The memory model's acknowledge latency is switched between zero and three cycles, so both back-to-back reads and requests held across wait cycles get exercised.

// File: rtl/ecap_walker_pkg.sv
package ecap_walker_pkg;

   localparam int WORD_W = 32;
   localparam int PTR_W  = 12;

   typedef struct packed {
      logic [PTR_W-1:0] next_ptr;
      logic [3:0]       version;
      logic [15:0]      cap_id;
   } cap_hdr_t;

   typedef struct packed {
      logic [PTR_W-1:0] length;
      logic [3:0]       revision;
      logic [15:0]      sub_id;
   } vsec_hdr_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_HDR   = 2'd2,
      ST_VSEC  = 2'd3
   } walk_state_e;

endpackage

// File: rtl/ecap_rd_port.sv
module ecap_rd_port #(
   parameter int OFS_W  = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [OFS_W-1:0]  issue_addr_i,
   output logic              rsp_valid_o,
   output logic [DATA_W-1:0] rsp_data_o,
   output logic              rd_req_o,
   output logic [OFS_W-1:0]  rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i
);

   logic              req_q;
   logic [OFS_W-1:0]  addr_q;
   logic              vld_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         addr_q <= '0;
         vld_q  <= 1'b0;
         data_q <= '0;
      end else begin
         vld_q <= 1'b0;
         if (req_q && rd_ack_i) begin
            req_q  <= 1'b0;
            vld_q  <= 1'b1;
            data_q <= rd_data_i;
         end else if (issue_i && !req_q) begin
            req_q  <= 1'b1;
            addr_q <= issue_addr_i;
         end
      end
   end

   assign rd_req_o    = req_q;
   assign rd_addr_o   = addr_q;
   assign rsp_valid_o = vld_q;
   assign rsp_data_o  = data_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)))
      else $error("request dropped or address moved before acknowledge"); // R11
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |-> !rd_req_o)
      else $error("new read issued while one is outstanding"); // R11
   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_ack_i) |=> (!rd_req_o && rsp_valid_o))
      else $error("request not retired after acknowledge"); // R11

endmodule

// File: rtl/ecap_hdr_decode.sv
module ecap_hdr_decode
   import ecap_walker_pkg::*;
#(
   parameter logic [15:0]      VNDR_CAP_ID = 16'h000B,
   parameter logic [15:0]      TGT_SUB_ID  = 16'h0008,
   parameter logic [PTR_W-1:0] TGT_LEN     = 12'h020
) (
   input  logic [WORD_W-1:0] word_i,
   output logic              is_vndr_o,
   output logic [PTR_W-1:0]  next_ptr_o,
   output logic              vsec_match_o
);

   cap_hdr_t  cap_w;
   vsec_hdr_t vsec_w;

   assign cap_w  = cap_hdr_t'(word_i);
   assign vsec_w = vsec_hdr_t'(word_i);

   assign is_vndr_o    = (cap_w.cap_id == VNDR_CAP_ID);
   assign next_ptr_o   = cap_w.next_ptr;
   assign vsec_match_o = (vsec_w.sub_id == TGT_SUB_ID) && (vsec_w.length == TGT_LEN);

endmodule

// File: rtl/ecap_bounds.sv
module ecap_bounds #(
   parameter int OFS_W       = 12,
   parameter int SPACE_BYTES = 4096,
   parameter int LIST_BASE   = 256,
   parameter int CAP_BYTES   = 32
) (
   input  logic [OFS_W-1:0] ofs_i,
   output logic             walk_ok_o,
   output logic             sub_ok_o,
   output logic             found_ok_o
);

   localparam int XW = OFS_W + 1;
   localparam logic [XW-1:0] WALK_MAX  = XW'(SPACE_BYTES - 4);
   localparam logic [XW-1:0] SUB_MAX   = XW'(SPACE_BYTES - 8);
   localparam logic [XW-1:0] FOUND_MAX = XW'(SPACE_BYTES - CAP_BYTES);

   logic [XW-1:0] ofs_x;
   logic          low_ok;

   assign ofs_x = {1'b0, ofs_i};

   generate
      if (LIST_BASE == 0) begin : g_no_floor
         assign low_ok = 1'b1;
      end else begin : g_floor
         localparam logic [XW-1:0] FLOOR = XW'(LIST_BASE);
         assign low_ok = (ofs_x >= FLOOR);
      end
   endgenerate

   assign walk_ok_o  = low_ok && (ofs_x <= WALK_MAX);
   assign sub_ok_o   = (ofs_x <= SUB_MAX);
   assign found_ok_o = low_ok && (ofs_x <= FOUND_MAX);

endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
   import ecap_walker_pkg::*;
#(
   parameter int               SPACE_BYTES = 4096,
   parameter int               LIST_BASE   = 256,
   parameter logic [15:0]      VNDR_CAP_ID = 16'h000B,
   parameter logic [15:0]      TGT_SUB_ID  = 16'h0008,
   parameter logic [PTR_W-1:0] TGT_LEN     = 12'h020,
   localparam int              OFS_W       = $clog2(SPACE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              found_o,
   output logic [OFS_W-1:0]  cap_ofs_o,
   output logic              rd_req_o,
   output logic [OFS_W-1:0]  rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [WORD_W-1:0] rd_data_i
);

   localparam int CAP_BYTES = int'(TGT_LEN);
   localparam logic [OFS_W-1:0] BASE_OFS = OFS_W'(LIST_BASE);
   localparam logic [OFS_W-1:0] SUB_STEP = OFS_W'(4);

   generate
      if (SPACE_BYTES != (1 << OFS_W)) begin : g_bad_space
         $error("SPACE_BYTES must be a power of two");
      end
      if (OFS_W < PTR_W) begin : g_bad_ptr
         $error("space too small for the next-pointer field");
      end
      if (LIST_BASE > SPACE_BYTES - 4) begin : g_bad_base
         $error("LIST_BASE lies outside the space");
      end
      if (CAP_BYTES < 8 || CAP_BYTES > SPACE_BYTES - LIST_BASE) begin : g_bad_len
         $error("TGT_LEN does not fit the extended space");
      end
   endgenerate

   walk_state_e       state_q;
   logic [OFS_W-1:0]  cur_q;
   logic [PTR_W-1:0]  nxt_q;
   logic              found_q;
   logic [OFS_W-1:0]  ofs_q;
   logic              done_q;

   logic              issue;
   logic [OFS_W-1:0]  issue_addr;
   logic              rsp_valid;
   logic [WORD_W-1:0] rsp_data;
   logic              is_vndr;
   logic [PTR_W-1:0]  next_ptr;
   logic              vsec_match;
   logic              walk_ok;
   logic              sub_ok;
   logic              found_ok;

   ecap_rd_port #(
      .OFS_W  (OFS_W),
      .DATA_W (WORD_W)
   ) u_rd_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_i      (issue),
      .issue_addr_i (issue_addr),
      .rsp_valid_o  (rsp_valid),
      .rsp_data_o   (rsp_data),
      .rd_req_o     (rd_req_o),
      .rd_addr_o    (rd_addr_o),
      .rd_ack_i     (rd_ack_i),
      .rd_data_i    (rd_data_i)
   );

   ecap_hdr_decode #(
      .VNDR_CAP_ID (VNDR_CAP_ID),
      .TGT_SUB_ID  (TGT_SUB_ID),
      .TGT_LEN     (TGT_LEN)
   ) u_decode (
      .word_i       (rsp_data),
      .is_vndr_o    (is_vndr),
      .next_ptr_o   (next_ptr),
      .vsec_match_o (vsec_match)
   );

   ecap_bounds #(
      .OFS_W       (OFS_W),
      .SPACE_BYTES (SPACE_BYTES),
      .LIST_BASE   (LIST_BASE),
      .CAP_BYTES   (CAP_BYTES)
   ) u_bounds (
      .ofs_i      (cur_q),
      .walk_ok_o  (walk_ok),
      .sub_ok_o   (sub_ok),
      .found_ok_o (found_ok)
   );

   always_comb begin
      issue      = 1'b0;
      issue_addr = cur_q;
      if (state_q == ST_CHECK && walk_ok) begin
         issue = 1'b1;
      end else if (state_q == ST_HDR && rsp_valid && is_vndr && sub_ok) begin
         issue      = 1'b1;
         issue_addr = cur_q + SUB_STEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         nxt_q   <= '0;
         found_q <= 1'b0;
         ofs_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  cur_q   <= BASE_OFS;
                  found_q <= 1'b0;
                  ofs_q   <= '0;
                  state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (walk_ok) begin
                  state_q <= ST_HDR;
               end else begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            ST_HDR: begin
               if (rsp_valid) begin
                  if (!is_vndr) begin
                     cur_q   <= OFS_W'(next_ptr);
                     state_q <= ST_CHECK;
                  end else if (sub_ok) begin
                     nxt_q   <= next_ptr;
                     state_q <= ST_VSEC;
                  end else begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            ST_VSEC: begin
               if (rsp_valid) begin
                  if (vsec_match) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     found_q <= found_ok;
                     ofs_q   <= found_ok ? cur_q : '0;
                  end else begin
                     cur_q   <= OFS_W'(nxt_q);
                     state_q <= ST_CHECK;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;
   assign found_o   = found_q;
   assign cap_ofs_o = ofs_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("done held longer than one cycle"); // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o)
      else $error("done while still busy"); // R2
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(found_o) && $stable(cap_ofs_o)))
      else $error("result changed while idle"); // R10
   AST_FOUND_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> (int'(cap_ofs_o) >= LIST_BASE && int'(cap_ofs_o) <= SPACE_BYTES - CAP_BYTES))
      else $error("found offset outside window"); // R8
   AST_READ_IN_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (int'(rd_addr_o) <= SPACE_BYTES - 4))
      else $error("read beyond the space"); // R7
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_req_o)
      else $error("read request while idle"); // R2

endmodule

// File: tb/ecap_walker_tb.sv
module ecap_walker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done, found;
   logic [11:0] cap_ofs;
   logic        req;
   logic [11:0] addr;
   logic        ack;
   logic [31:0] rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   ecap_walker dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .busy_o    (busy),
      .done_o    (done),
      .found_o   (found),
      .cap_ofs_o (cap_ofs),
      .rd_req_o  (req),
      .rd_addr_o (addr),
      .rd_ack_i  (ack),
      .rd_data_i (rdata)
   );

   // configuration-space model
   logic [31:0] mem [0:1023];
   logic [11:0] rd_log [0:255];
   int          lat = 0;
   int          wait_cnt = 0;
   int          rd_cnt = 0;
   int          hold_err = 0;
   logic        prev_req = 1'b0, prev_ack = 1'b0;
   logic [11:0] prev_addr = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ack      <= 1'b0;
         rdata    <= '0;
         wait_cnt <= 0;
      end else begin
         ack <= 1'b0;
         if (req && !ack) begin
            if (wait_cnt >= lat) begin
               ack              <= 1'b1;
               rdata            <= mem[addr[11:2]];
               rd_log[rd_cnt[7:0]] <= addr;
               rd_cnt           <= rd_cnt + 1;
               wait_cnt         <= 0;
            end else begin
               wait_cnt <= wait_cnt + 1;
            end
         end
      end
   end

   // request-hold monitor for R11
   always @(posedge clk) begin
      if (rst_n && prev_req && !prev_ack && (!req || addr != prev_addr))
         hold_err <= hold_err + 1;
      prev_req  <= req;
      prev_ack  <= ack;
      prev_addr <= addr;
   end

   function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] ver,
                                       input logic [11:0] nxt);
      return {nxt, ver, id};
   endfunction

   function automatic logic [31:0] vsec(input logic [15:0] sub, input logic [3:0] rev,
                                        input logic [11:0] len);
      return {len, rev, sub};
   endfunction

   task automatic put(input logic [11:0] ofs, input logic [31:0] w);
      mem[ofs[11:2]] = w;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 1024; i++) mem[i] = '0;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // runs one walk; restart_at > 0 pulses start again that many cycles in
   task automatic run_walk(input int restart_at, output int reads);
      int base = rd_cnt;
      int cyc = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
      while (!done && cyc < 3000) begin
         if (restart_at > 0 && cyc == restart_at) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         cyc++;
      end
      chk(done == 1'b1, "R10 done seen", 32'(done), 1);
      chk(busy == 1'b0, "R2 busy low at done", 32'(busy), 0);
      reads = rd_cnt - base;
      @(negedge clk);
      chk(done == 1'b0, "R10 done one cycle", 32'(done), 0);
   endtask

   task automatic expect_result(input string tag, input int reads, input int exp_reads,
                                input bit exp_found, input logic [11:0] exp_ofs);
      chk(found == exp_found, {tag, " found"}, 32'(found), 32'(exp_found));
      chk(cap_ofs == exp_ofs, {tag, " offset"}, 32'(cap_ofs), 32'(exp_ofs));
      chk(reads == exp_reads, {tag, " read count"}, reads, exp_reads);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !found && !req, "R1 flags after reset",
          {28'd0, busy, done, found, req}, 0);
      chk(cap_ofs == 0, "R1 offset after reset", 32'(cap_ofs), 0);
   endtask

   task automatic t_direct();
      int n;
      clear_mem(); lat = 0;
      put(12'h100, hdr(16'h000B, 4'h1, 12'h000));
      put(12'h104, vsec(16'h0008, 4'h3, 12'h020));
      run_walk(0, n);
      expect_result("R4 direct match", n, 2, 1'b1, 12'h100);
      chk(rd_log[(rd_cnt - 2) % 256] == 12'h100, "R2 first read at 0x100",
          32'(rd_log[(rd_cnt - 2) % 256]), 32'h100);
      chk(rd_log[(rd_cnt - 1) % 256] == 12'h104, "R4 second word read",
          32'(rd_log[(rd_cnt - 1) % 256]), 32'h104);
   endtask

   task automatic load_chain();
      clear_mem();
      put(12'h100, hdr(16'h0001, 4'h1, 12'h140));
      put(12'h140, hdr(16'h000B, 4'h1, 12'h200));
      put(12'h144, vsec(16'h0009, 4'h0, 12'h020));
      put(12'h200, hdr(16'h000B, 4'h1, 12'h300));
      put(12'h204, vsec(16'h0008, 4'h0, 12'h024));
      put(12'h300, hdr(16'h000B, 4'h2, 12'h000));
      put(12'h304, vsec(16'h0008, 4'h5, 12'h020));
   endtask

   task automatic t_chain();
      int n;
      load_chain(); lat = 3;
      run_walk(0, n);
      expect_result("R5 chain with mismatches", n, 7, 1'b1, 12'h300);
      chk(rd_log[(rd_cnt - 6) % 256] == 12'h140, "R3 pointer followed",
          32'(rd_log[(rd_cnt - 6) % 256]), 32'h140);
      chk(hold_err == 0, "R11 request held until ack", hold_err, 0);
   endtask

   task automatic t_zero_ptr();
      int n;
      clear_mem(); lat = 0;
      put(12'h100, hdr(16'h0002, 4'h1, 12'h180));
      put(12'h180, hdr(16'h0003, 4'h1, 12'h000));
      run_walk(0, n);
      expect_result("R6 zero pointer", n, 2, 1'b0, 12'h000);
   endtask

   task automatic t_low_ptr();
      int n;
      clear_mem(); lat = 1;
      put(12'h100, hdr(16'h0001, 4'h1, 12'h0F0));
      put(12'h0F0, hdr(16'h000B, 4'h1, 12'h000));
      put(12'h0F4, vsec(16'h0008, 4'h0, 12'h020));
      run_walk(0, n);
      expect_result("R6 pointer below 0x100", n, 1, 1'b0, 12'h000);
   endtask

   task automatic t_high_ptr();
      int n;
      clear_mem(); lat = 0;
      put(12'h100, hdr(16'h0001, 4'h1, 12'hFFF));
      run_walk(0, n);
      expect_result("R7 pointer above 4092", n, 1, 1'b0, 12'h000);
   endtask

   task automatic t_upper_ok();
      int n;
      clear_mem(); lat = 2;
      put(12'h100, hdr(16'h0001, 4'h1, 12'hFE0));
      put(12'hFE0, hdr(16'h000B, 4'h1, 12'h000));
      put(12'hFE4, vsec(16'h0008, 4'h1, 12'h020));
      run_walk(0, n);
      expect_result("R8 match at 0xFE0", n, 3, 1'b1, 12'hFE0);
   endtask

   task automatic t_upper_bad();
      int n;
      clear_mem(); lat = 0;
      put(12'h100, hdr(16'h0001, 4'h1, 12'hFE4));
      put(12'hFE4, hdr(16'h000B, 4'h1, 12'h000));
      put(12'hFE8, vsec(16'h0008, 4'h1, 12'h020));
      run_walk(0, n);
      expect_result("R8 match at 0xFE4", n, 3, 1'b0, 12'h000);
   endtask

   task automatic t_vsec_out();
      int n;
      clear_mem(); lat = 0;
      put(12'h100, hdr(16'h0001, 4'h1, 12'hFFC));
      put(12'hFFC, hdr(16'h000B, 4'h1, 12'h100));
      run_walk(0, n);
      expect_result("R9 second word outside space", n, 2, 1'b0, 12'h000);
   endtask

   task automatic t_hold();
      int n;
      clear_mem(); lat = 0;
      put(12'h100, hdr(16'h000B, 4'h1, 12'h000));
      put(12'h104, vsec(16'h0008, 4'h0, 12'h020));
      run_walk(0, n);
      repeat (6) @(negedge clk);
      chk(found == 1'b1 && cap_ofs == 12'h100, "R10 result holds while idle",
          {19'd0, found, cap_ofs}, {19'd0, 1'b1, 12'h100});
      put(12'h100, hdr(16'h0001, 4'h1, 12'h000));
      lat = 4;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(found == 1'b0 && cap_ofs == 12'h000, "R10 start clears result",
          {19'd0, found, cap_ofs}, 0);
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_busy_start();
      int n;
      load_chain(); lat = 3;
      run_walk(5, n);
      expect_result("R12 start while busy ignored", n, 7, 1'b1, 12'h300);
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R12 no second walk", 32'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_direct();
      t_chain();
      t_zero_ptr();
      t_low_ptr();
      t_high_ptr();
      t_upper_ok();
      t_upper_bad();
      t_vsec_out();
      t_hold();
      t_busy_start();
      chk(hold_err == 0, "R11 request stability over all walks", hold_err, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule